// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small load/store processor and decides, once per finished instruction, where the counter goes next. It takes the opcode of the current instruction, two of its 3-bit register fields and the value read from the first source register. From these it picks one of three outcomes: step forward by one, jump relative by a 6-bit signed offset, or load the counter with the register value.

Two conditional relative branches are supported. One is taken when the source register is zero. The other is taken when the source register is negative, meaning its top bit is set. The branch offset is built from two fields. The destination field forms the upper three bits and the second-source field forms the lower three bits, and the 6-bit result is read as two's complement. An indirect jump copies the register value into the counter. Every other opcode simply advances the counter.

The counter only moves in a cycle where the instruction-complete strobe is high. Fetching the instruction and reading the register file are done by neighbouring logic.

Top module: `pc_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the counter reads 0x0000.
- R2: In a cycle where `done_i` is low, the counter keeps its value whatever the other inputs are.
- R3: When `done_i` is high and the opcode is none of the three control opcodes, the counter becomes counter + 1, wrapping from 0xFFFF to 0x0000.
- R4: Opcode 7'b1100000 (zero branch) with `src_val_i` equal to 0 sets the counter to counter + offset. The offset is {`dst_fld_i`, `srcb_fld_i`} read as 6-bit two's complement, giving a range of -32 to +31.
- R5: Opcode 7'b1100000 with `src_val_i` nonzero advances the counter by 1.
- R6: Opcode 7'b1100001 (negative branch) is taken when bit 15 of `src_val_i` is 1 and applies the R4 offset. Otherwise it advances the counter by 1.
- R7: Opcode 7'b1110000 (jump) loads the counter with `src_val_i`.
- R8: Relative branch addition wraps modulo 2^16. For example, counter 0x0002 with offset -5 gives 0xFFFD.
- R9: Opcodes that differ from a control opcode by one bit, such as 7'b1100010, 7'b1100011 and 7'b1110001, advance the counter by 1 even when a branch condition would hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| opc_i | input | 7 | Opcode field of the current instruction |
| dst_fld_i | input | 3 | Destination-register field; upper half of the branch offset |
| srcb_fld_i | input | 3 | Second-source field; lower half of the branch offset |
| src_val_i | input | 16 | Value of the first source register |
| done_i | input | 1 | Instruction-complete strobe; the counter updates only when high |
| pc_o | output | 16 | Program counter |

## Verification
The hardest cases are the branch offset at its signed limits combined with wrap-around, and a jump-to-register near the top of the address space. These only arise when the counter has first been steered to a specific value. The stimulus uses the jump opcode to place the counter at 0x0002 or 0xFFFF. It then issues a branch with offset -5, +31 or -32, or a plain instruction, so that the wrapped results can be compared against independently computed values. Opcodes one bit away from the control codes are applied with the zero and negative conditions both true. This shows that the decode does not match on partial opcodes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    K_SEQ = 2'd0,
    K_BRZ = 2'd1,
    K_BRN = 2'd2,
    K_JMP = 2'd3
  } kind_e;

  localparam int          OPC_W   = 7;
  localparam logic [6:0]  OPC_BRZ = 7'b1100000;
  localparam logic [6:0]  OPC_BRN = 7'b1100001;
  localparam logic [6:0]  OPC_JMP = 7'b1110000;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int FLD_W  = 3,
  parameter int ADDR_W = 16
) (
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [FLD_W-1:0]  hi_fld_i,
  input  logic [FLD_W-1:0]  lo_fld_i,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] off_o
);

  localparam int OFF_W = 2 * FLD_W;
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] raw_off;

  always_comb begin
    unique case (opc_i)
      OPC_BRZ: kind_o = K_BRZ;
      OPC_BRN: kind_o = K_BRN;
      OPC_JMP: kind_o = K_JMP;
      default: kind_o = K_SEQ;
    endcase
  end

  assign raw_off = {hi_fld_i, lo_fld_i};
  assign off_o   = {{EXT_W{raw_off[OFF_W-1]}}, raw_off};

endmodule

// File: rtl/pcu_next.sv
module pcu_next
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] src_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] off_i,
  output logic [ADDR_W-1:0] nxt_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic src_zero;
  logic src_neg;
  logic take_rel;

  assign src_zero = (src_i == '0);
  assign src_neg  = src_i[ADDR_W-1];

  always_comb begin
    take_rel = 1'b0;
    case (kind_i)
      K_BRZ:   take_rel = src_zero;
      K_BRN:   take_rel = src_neg;
      default: take_rel = 1'b0;
    endcase
  end

  always_comb begin
    if (kind_i == K_JMP) nxt_o = src_i;
    else if (take_rel)   nxt_o = pc_i + off_i;
    else                 nxt_o = pc_i + ONE;
  end

endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] nxt_i,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    pc_d = pc_q;
    if (en_i) pc_d = nxt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  always @(posedge clk) begin
    if (!rst_n) p_reset_zero_r1: assert (pc_q == '0);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(pc_q));

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int FLD_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        opc_i,
  input  logic [FLD_W-1:0]  dst_fld_i,
  input  logic [FLD_W-1:0]  srcb_fld_i,
  input  logic [ADDR_W-1:0] src_val_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] pc_o
);

  localparam int OFF_W = 2 * FLD_W;

  logic              rst_sync_n;
  kind_e             kind;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] nxt;

  pcu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  pcu_decode #(.FLD_W(FLD_W), .ADDR_W(ADDR_W)) u_dec (
    .opc_i    (opc_i),
    .hi_fld_i (dst_fld_i),
    .lo_fld_i (srcb_fld_i),
    .kind_o   (kind),
    .off_o    (off)
  );

  pcu_next #(.ADDR_W(ADDR_W)) u_nxt (
    .pc_i   (pc_o),
    .src_i  (src_val_i),
    .kind_i (kind),
    .off_i  (off),
    .nxt_o  (nxt)
  );

  pcu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (done_i),
    .nxt_i (nxt),
    .pc_o  (pc_o)
  );

  logic [OFF_W-1:0]  chk_ad;
  logic [ADDR_W-1:0] chk_sext;
  assign chk_ad   = {dst_fld_i, srcb_fld_i};
  assign chk_sext = ADDR_W'($signed(chk_ad));

  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && opc_i != OPC_BRZ && opc_i != OPC_BRN && opc_i != OPC_JMP)
      |=> pc_o == $past(pc_o) + ADDR_W'(1));

  p_brz_take_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && opc_i == OPC_BRZ && src_val_i == '0)
      |=> pc_o == $past(pc_o) + $past(chk_sext));

  p_brz_skip_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && opc_i == OPC_BRZ && src_val_i != '0)
      |=> pc_o == $past(pc_o) + ADDR_W'(1));

  p_brn_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && opc_i == OPC_BRN)
      |=> pc_o == ($past(src_val_i[ADDR_W-1]) ? $past(pc_o) + $past(chk_sext)
                                               : $past(pc_o) + ADDR_W'(1)));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_i && opc_i == OPC_JMP) |=> pc_o == $past(src_val_i));

endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;

  localparam int CLK_P = 10;

  localparam logic [6:0] OP_BRZ = 7'b1100000;
  localparam logic [6:0] OP_BRN = 7'b1100001;
  localparam logic [6:0] OP_JMP = 7'b1110000;
  localparam logic [6:0] OP_ADD = 7'b0000010;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  opc;
  logic [2:0]  dst_fld;
  logic [2:0]  srcb_fld;
  logic [15:0] src_val;
  logic        done;
  logic [15:0] pc;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pc_branch_unit u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .opc_i      (opc),
    .dst_fld_i  (dst_fld),
    .srcb_fld_i (srcb_fld),
    .src_val_i  (src_val),
    .done_i     (done),
    .pc_o       (pc)
  );

  task automatic check(input string req, input logic [15:0] exp);
    total++;
    if (pc !== exp) begin
      bad++;
      $display("FAIL %s: pc=%h expected=%h", req, pc, exp);
    end
  endtask

  task automatic step(input logic [6:0] op, input logic [2:0] hi,
                      input logic [2:0] lo, input logic [15:0] v, input logic dn);
    @(negedge clk);
    opc = op; dst_fld = hi; srcb_fld = lo; src_val = v; done = dn;
    @(posedge clk);
    #1;
    done = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    #1 check("R1 reset value", 16'h0000);
  endtask

  task automatic t_hold;
    step(OP_JMP, 3'd0, 3'd0, 16'h1234, 1'b0);
    check("R2 hold on jump without strobe", 16'h0000);
    step(OP_ADD, 3'd0, 3'd0, 16'h0000, 1'b0);
    check("R2 hold on plain op without strobe", 16'h0000);
  endtask

  task automatic t_seq;
    step(OP_ADD, 3'd1, 3'd2, 16'h0000, 1'b1);
    check("R3 step one", 16'h0001);
    step(7'b0010000, 3'd7, 3'd7, 16'h8000, 1'b1);
    check("R3 step two", 16'h0002);
    step(OP_JMP, 3'd0, 3'd0, 16'hFFFF, 1'b1);
    step(OP_ADD, 3'd0, 3'd0, 16'h0000, 1'b1);
    check("R3 wrap FFFF to 0", 16'h0000);
  endtask

  task automatic t_jump;
    step(OP_JMP, 3'd5, 3'd5, 16'h0100, 1'b1);
    check("R7 jump loads register", 16'h0100);
  endtask

  task automatic t_brz;
    step(OP_BRZ, 3'b000, 3'b011, 16'h0000, 1'b1);
    check("R4 zero branch +3", 16'h0103);
    step(OP_BRZ, 3'b011, 3'b111, 16'h0000, 1'b1);
    check("R4 zero branch +31", 16'h0122);
    step(OP_BRZ, 3'b100, 3'b000, 16'h0000, 1'b1);
    check("R4 zero branch -32", 16'h0102);
    step(OP_BRZ, 3'b011, 3'b111, 16'h0005, 1'b1);
    check("R5 zero branch not taken", 16'h0103);
  endtask

  task automatic t_brn;
    step(OP_BRN, 3'b111, 3'b011, 16'h8000, 1'b1);
    check("R6 negative branch -5", 16'h00FE);
    step(OP_BRN, 3'b111, 3'b011, 16'h7FFF, 1'b1);
    check("R6 negative branch not taken", 16'h00FF);
    step(OP_BRN, 3'b111, 3'b011, 16'h0000, 1'b1);
    check("R6 zero is not negative", 16'h0100);
  endtask

  task automatic t_wrap;
    step(OP_JMP, 3'd0, 3'd0, 16'h0002, 1'b1);
    step(OP_BRN, 3'b111, 3'b011, 16'hFFFF, 1'b1);
    check("R8 backward wrap", 16'hFFFD);
    step(OP_BRZ, 3'b001, 3'b000, 16'h0000, 1'b1);
    check("R8 forward wrap", 16'h0005);
  endtask

  task automatic t_near;
    step(7'b1100010, 3'b001, 3'b000, 16'h0000, 1'b1);
    check("R9 opcode 1100010 sequential", 16'h0006);
    step(7'b1100011, 3'b001, 3'b000, 16'h8000, 1'b1);
    check("R9 opcode 1100011 sequential", 16'h0007);
    step(7'b1110001, 3'b000, 3'b000, 16'hABCD, 1'b1);
    check("R9 opcode 1110001 sequential", 16'h0008);
    step(7'b0100000, 3'b000, 3'b000, 16'h0000, 1'b1);
    check("R9 opcode 0100000 sequential", 16'h0009);
  endtask

  task automatic t_reset_mid;
    step(OP_JMP, 3'd0, 3'd0, 16'h4242, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 asynchronous clear mid-run", 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(OP_ADD, 3'd0, 3'd0, 16'h0000, 1'b1);
    check("R1 held at zero on first clock after release", 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; opc = '0; dst_fld = '0; srcb_fld = '0; src_val = '0; done = 1'b0;
    t_reset();
    t_hold();
    t_seq();
    t_jump();
    t_brz();
    t_brn();
    t_wrap();
    t_near();
    t_reset_mid();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!ended) begin
      ended = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule